// File: doc/BRIEF.md
# Byte-to-Word Disk Register Bridge

This block lets an 8-bit processor bus with a clock-phase qualifier reach the task registers of a 16-bit disk drive interface. A 32-byte decoded window carries two register groups, a primary and a secondary. Each group is followed by an 8-byte slot that mirrors a single high-byte holding location. The low data byte passes straight between the two buses. The upper byte of every 16-bit word goes through one of two holding registers: a read-side one, filled when the data register is read, and a write-side one, loaded by software before the data register is written.

Every drive strobe and every output enable is a pure function of the select, phase and address inputs. Only the two holding registers are clocked, and they sample while the qualifying strobe is active. Software reads a word by reading the data register and then any high-byte location. It writes a word by writing a high-byte location and then the data register.

Top module: `ide_byte_bridge`

## Requirements
- R1: Window offset bit 3 clear selects a task register: offset bit 4 clear asserts drive select 0 (ide_cs_no = 2'b10), and bit 4 set asserts drive select 1 (ide_cs_no = 2'b01). With offset bit 3 set, neither drive select is asserted.
- R2: Drive selects, read/write strobes and both data output enables are asserted only while cs_ni is low and phi2_i is high.
- R3: For a task-register access, rw_i high asserts ide_rd_no and rw_i low asserts ide_wr_no. The two are never low together.
- R4: ide_reg_o carries offset bits 2..0 during a task-register access.
- R5: A read of register 0 of either group returns ide_dat_i[7:0] on cpu_dat_o. At the clock edge during that strobe, the read holding register captures ide_dat_i[15:8].
- R6: A read at any offset in 0x08..0x0F or 0x18..0x1F returns the read holding register, with cpu_dat_oe_o high and no drive strobe.
- R7: A write at any offset in 0x08..0x0F or 0x18..0x1F loads cpu_dat_i into the write holding register and asserts no drive strobe.
- R8: A task-register write drives ide_dat_o = {write holding register, cpu_dat_i} with ide_dat_oe_o high. ide_dat_oe_o is low whenever ide_wr_no is high.
- R9: rst_ni low clears both holding registers and forces all drive strobes high, even while an access is being presented.
- R10: Reading a task register other than register 0 leaves the read holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the holding registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low window select |
| rw_i | input | 1 | 1 = read, 0 = write |
| phi2_i | input | 1 | Processor phase qualifier, active high |
| addr_i | input | 5 | Offset inside the window |
| cpu_dat_i | input | 8 | Byte from the processor |
| cpu_dat_o | output | 8 | Byte to the processor |
| cpu_dat_oe_o | output | 1 | Processor data output enable |
| ide_cs_no | output | 2 | Active-low drive selects, bit 0 primary, bit 1 secondary |
| ide_reg_o | output | 3 | Drive register address |
| ide_rd_no | output | 1 | Active-low drive read strobe |
| ide_wr_no | output | 1 | Active-low drive write strobe |
| ide_dat_i | input | 16 | Word from the drive |
| ide_dat_o | output | 16 | Word to the drive |
| ide_dat_oe_o | output | 1 | Drive data output enable |

## Verification
The assertions check the following on every cycle: strobe gating by select and phase, the mutual exclusion of the read and write strobes and of the two drive selects, the capture of the upper drive byte after a data-register read, and the stability of each holding register while it is not loaded. The bench scenarios are needed to show that the high-byte slots really mirror across all eight offsets and both groups. They also show that only register 0 fills the read holder, that a written high byte reaches the drive word on the following data write, and that reset clears the holders in the middle of an access.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_PRI  = 2'd1,
    RG_SEC  = 2'd2,
    RG_HI   = 2'd3
  } region_e;
endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_bridge_pkg::*;
#(
  parameter int REG_W  = 3,
  parameter int ADDR_W = REG_W + 2
) (
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              phi2_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              act_o,
  output region_e           region_o
);
  localparam int HI_BIT  = REG_W;
  localparam int GRP_BIT = REG_W + 1;

  assign act_o = rst_ni && !cs_ni && phi2_i;

  always_comb begin
    if (!act_o)                region_o = RG_NONE;
    else if (addr_i[HI_BIT])   region_o = RG_HI;
    else if (addr_i[GRP_BIT])  region_o = RG_SEC;
    else                       region_o = RG_PRI;
  end
endmodule

// File: rtl/ide_hold_reg.sv
module ide_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  // holder keeps its value unless loaded (R7, R10)
  assert_hold_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge
  import ide_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 3,
  parameter int ADDR_W = REG_W + 2,
  parameter int WORD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rw_i,
  input  logic              phi2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] cpu_dat_i,
  output logic [DATA_W-1:0] cpu_dat_o,
  output logic              cpu_dat_oe_o,
  output logic [1:0]        ide_cs_no,
  output logic [REG_W-1:0]  ide_reg_o,
  output logic              ide_rd_no,
  output logic              ide_wr_no,
  input  logic [WORD_W-1:0] ide_dat_i,
  output logic [WORD_W-1:0] ide_dat_o,
  output logic              ide_dat_oe_o
);
  logic              act;
  region_e           region;
  logic              task_acc;
  logic              rd_ld, wr_ld;
  logic [DATA_W-1:0] rd_hi_q, wr_hi_q;

  ide_win_decode #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_dec (
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .phi2_i   (phi2_i),
    .addr_i   (addr_i),
    .act_o    (act),
    .region_o (region)
  );

  assign task_acc = (region == RG_PRI) || (region == RG_SEC);

  // upper drive byte captured only on register 0 reads
  assign rd_ld = task_acc && rw_i && (addr_i[REG_W-1:0] == '0);
  assign wr_ld = (region == RG_HI) && !rw_i;

  ide_hold_reg #(.W(DATA_W)) u_rd_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (rd_ld),
    .d_i   (ide_dat_i[WORD_W-1:DATA_W]),
    .q_o   (rd_hi_q)
  );

  ide_hold_reg #(.W(DATA_W)) u_wr_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (wr_ld),
    .d_i   (cpu_dat_i),
    .q_o   (wr_hi_q)
  );

  assign ide_cs_no[0] = !(region == RG_PRI);
  assign ide_cs_no[1] = !(region == RG_SEC);
  assign ide_reg_o    = addr_i[REG_W-1:0];
  assign ide_rd_no    = !(task_acc && rw_i);
  assign ide_wr_no    = !(task_acc && !rw_i);

  assign ide_dat_oe_o = task_acc && !rw_i;
  assign ide_dat_o    = {wr_hi_q, cpu_dat_i};

  assign cpu_dat_oe_o = act && rw_i;
  assign cpu_dat_o    = (region == RG_HI) ? rd_hi_q : ide_dat_i[DATA_W-1:0];

  assert_cs_onehot0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ide_cs_no) <= 1);

  assert_strobe_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ide_rd_no || !ide_wr_no || ide_cs_no != 2'b11) |-> (!cs_ni && phi2_i));

  assert_rd_wr_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ide_rd_no && !ide_wr_no));

  assert_rd_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ide_rd_no && ide_reg_o == '0) |=> rd_hi_q == $past(ide_dat_i[WORD_W-1:DATA_W]));

  assert_drive_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ide_dat_oe_o |-> (!ide_wr_no && !cpu_dat_oe_o));
endmodule

// File: tb/ide_byte_bridge_bench.sv
module ide_byte_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, rw_i = 1'b1, phi2_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [7:0]  cpu_dat_i = '0;
  logic [15:0] ide_dat_i = '0;
  logic [7:0]  cpu_dat_o;
  logic        cpu_dat_oe_o;
  logic [1:0]  ide_cs_no;
  logic [2:0]  ide_reg_o;
  logic        ide_rd_no, ide_wr_no;
  logic [15:0] ide_dat_o;
  logic        ide_dat_oe_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ide_byte_bridge u_ide_byte_bridge (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rw_i(rw_i), .phi2_i(phi2_i),
    .addr_i(addr_i), .cpu_dat_i(cpu_dat_i), .cpu_dat_o(cpu_dat_o),
    .cpu_dat_oe_o(cpu_dat_oe_o), .ide_cs_no(ide_cs_no), .ide_reg_o(ide_reg_o),
    .ide_rd_no(ide_rd_no), .ide_wr_no(ide_wr_no), .ide_dat_i(ide_dat_i),
    .ide_dat_o(ide_dat_o), .ide_dat_oe_o(ide_dat_oe_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        cs_n, rw, phi2;
    logic [4:0]  addr;
    logic [7:0]  cd;
    logic [15:0] id;
    logic [1:0]  e_cs;
    logic        e_rd, e_wr;
    logic [2:0]  e_reg;
    logic        e_ioe;
    logic [15:0] e_ido;
    logic        e_coe;
    logic [7:0]  e_cdo;
  } vec_t;

  // applied in order after reset; holders start at zero
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b1,1'b1,1'b1, 5'h00, 8'h00, 16'h1234, 2'b11,1'b1,1'b1,3'd0,1'b0,16'h0000,1'b0,8'h00}, // R2 deselected
    '{4'd2,  1'b0,1'b1,1'b0, 5'h00, 8'h00, 16'h1234, 2'b11,1'b1,1'b1,3'd0,1'b0,16'h0000,1'b0,8'h00}, // R2 phase low
    '{4'd5,  1'b0,1'b1,1'b1, 5'h00, 8'h00, 16'hA55A, 2'b10,1'b0,1'b1,3'd0,1'b0,16'h0000,1'b1,8'h5A}, // R5 primary data read
    '{4'd6,  1'b0,1'b1,1'b1, 5'h0B, 8'h00, 16'h0000, 2'b11,1'b1,1'b1,3'd0,1'b0,16'h0000,1'b1,8'hA5}, // R6 mirror
    '{4'd6,  1'b0,1'b1,1'b1, 5'h1F, 8'h00, 16'h0000, 2'b11,1'b1,1'b1,3'd0,1'b0,16'h0000,1'b1,8'hA5}, // R6 second slot
    '{4'd1,  1'b0,1'b1,1'b1, 5'h13, 8'h00, 16'hFF77, 2'b01,1'b0,1'b1,3'd3,1'b0,16'h0000,1'b1,8'h77}, // R1 secondary reg3
    '{4'd10, 1'b0,1'b1,1'b1, 5'h08, 8'h00, 16'h0000, 2'b11,1'b1,1'b1,3'd0,1'b0,16'h0000,1'b1,8'hA5}, // R10 untouched
    '{4'd7,  1'b0,1'b0,1'b1, 5'h1C, 8'hC3, 16'h0000, 2'b11,1'b1,1'b1,3'd0,1'b0,16'h0000,1'b0,8'h00}, // R7 load write holder
    '{4'd8,  1'b0,1'b0,1'b1, 5'h10, 8'h3C, 16'h0000, 2'b01,1'b1,1'b0,3'd0,1'b1,16'hC33C,1'b0,8'h00}, // R8 secondary data write
    '{4'd4,  1'b0,1'b0,1'b1, 5'h06, 8'h99, 16'h0000, 2'b10,1'b1,1'b0,3'd6,1'b1,16'hC399,1'b0,8'h00}, // R4 reg 6 write
    '{4'd5,  1'b0,1'b1,1'b1, 5'h10, 8'h00, 16'h1E2F, 2'b01,1'b0,1'b1,3'd0,1'b0,16'h0000,1'b1,8'h2F}, // R5 secondary data read
    '{4'd6,  1'b0,1'b1,1'b1, 5'h0D, 8'h00, 16'h0000, 2'b11,1'b1,1'b1,3'd0,1'b0,16'h0000,1'b1,8'h1E}  // R6 new high byte
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic cs_n, input logic rw, input logic phi2,
                     input logic [4:0] a, input logic [7:0] cd, input logic [15:0] id);
    @(negedge clk);
    cs_ni = cs_n; rw_i = rw; phi2_i = phi2; addr_i = a; cpu_dat_i = cd; ide_dat_i = id;
    #1;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state with an access presented (R9)
    put(1'b0, 1'b0, 1'b1, 5'h00, 8'h11, 16'h0000);
    chk("R9 reset strobes", {12'h0, ide_cs_no, ide_rd_no, ide_wr_no}, 16'h000F);
    chk("R9 reset oe", {14'h0, ide_dat_oe_o, cpu_dat_oe_o}, 16'h0);
    put(1'b1, 1'b1, 1'b0, 5'h00, 8'h00, 16'h0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      put(VEC[i].cs_n, VEC[i].rw, VEC[i].phi2, VEC[i].addr, VEC[i].cd, VEC[i].id);
      total++;
      if (ide_cs_no !== VEC[i].e_cs || ide_rd_no !== VEC[i].e_rd ||
          ide_wr_no !== VEC[i].e_wr || ide_dat_oe_o !== VEC[i].e_ioe ||
          cpu_dat_oe_o !== VEC[i].e_coe ||
          (ide_cs_no != 2'b11 && ide_reg_o !== VEC[i].e_reg) ||
          (VEC[i].e_ioe && ide_dat_o !== VEC[i].e_ido) ||
          (VEC[i].e_coe && cpu_dat_o !== VEC[i].e_cdo)) begin
        bad++;
        $display("FAIL R%0d vec %0d act=%b/%b%b/%h/%b/%h/%b/%h exp=%b/%b%b/%h/%b/%h/%b/%h",
                 VEC[i].req, i, ide_cs_no, ide_rd_no, ide_wr_no, ide_reg_o, ide_dat_oe_o,
                 ide_dat_o, cpu_dat_oe_o, cpu_dat_o, VEC[i].e_cs, VEC[i].e_rd, VEC[i].e_wr,
                 VEC[i].e_reg, VEC[i].e_ioe, VEC[i].e_ido, VEC[i].e_coe, VEC[i].e_cdo);
      end
    end

    // R3: write with phase low gives no strobe (R2), with phase high gives write only
    put(1'b0, 1'b0, 1'b0, 5'h02, 8'h44, 16'h0000);
    chk("R2 write phase low", {13'h0, ide_wr_no, ide_dat_oe_o, ide_rd_no}, 16'h5);
    put(1'b0, 1'b0, 1'b1, 5'h02, 8'h44, 16'h0000);
    chk("R3 write strobe", {14'h0, ide_rd_no, ide_wr_no}, 16'h2);

    // R6: every mirror offset in both slots
    for (int a = 0; a < 8; a++) begin
      put(1'b0, 1'b1, 1'b1, 5'h08 + 5'(a), 8'h00, 16'h0000);
      chk("R6 mirror low slot", {8'h0, cpu_dat_o}, 16'h001E);
      put(1'b0, 1'b1, 1'b1, 5'h18 + 5'(a), 8'h00, 16'h0000);
      chk("R6 mirror high slot", {8'h0, cpu_dat_o}, 16'h001E);
    end

    // R10: reads of registers 1..7 do not touch the read holder
    for (int r = 1; r < 8; r++)
      put(1'b0, 1'b1, 1'b1, 5'(r), 8'h00, 16'hEE00);
    put(1'b0, 1'b1, 1'b1, 5'h0A, 8'h00, 16'h0000);
    chk("R10 holder after reg reads", {8'h0, cpu_dat_o}, 16'h001E);

    // R7: write through a different mirror offset, then R8 primary data write
    put(1'b0, 1'b0, 1'b1, 5'h09, 8'h6B, 16'h0000);
    chk("R7 no strobe on high write", {12'h0, ide_cs_no, ide_wr_no, ide_dat_oe_o}, 16'h000E);
    put(1'b0, 1'b0, 1'b1, 5'h00, 8'hD2, 16'h0000);
    chk("R8 drive word", ide_dat_o, 16'h6BD2);

    // R9: reset mid-access clears both holders
    put(1'b0, 1'b1, 1'b1, 5'h00, 8'h00, 16'h7700);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R9 strobe during reset", {15'h0, ide_rd_no}, 16'h1);
    put(1'b1, 1'b1, 1'b0, 5'h00, 8'h00, 16'h0000);
    rst_ni = 1'b1;
    put(1'b0, 1'b1, 1'b1, 5'h1A, 8'h00, 16'h0000);
    chk("R9 read holder cleared", {8'h0, cpu_dat_o}, 16'h0000);
    put(1'b0, 1'b0, 1'b1, 5'h11, 8'h5E, 16'h0000);
    chk("R9 write holder cleared", ide_dat_o, 16'h005E);

    put(1'b1, 1'b1, 1'b0, 5'h00, 8'h00, 16'h0000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule